// File: doc/BRIEF.md
# DMA Channel Status and Interrupt Coalescing

This block holds the status word and the interrupt logic for one memory-to-stream DMA channel. The data engine, the descriptor fetcher and the bus interface are outside it. They appear only as single-cycle event inputs:

- a packet finished, with a frame-end qualifier;
- the channel went idle;
- the channel became busy;
- the engine has shut down;
- six error classes.

The control register that holds run/stop, the interrupt enables, the threshold and the delay is also outside. Its bits arrive here as plain inputs.

On any error the block asserts a request that forces run/stop low. It reports Halted only once the engine confirms that it has fully stopped. Completion interrupts are coalesced by a threshold counter that counts down on each counted packet. A delay timer fires when packets are left pending for too long. Both values are visible live in the upper bytes of the status word. Software clears the three sticky interrupt flags by writing ones to them. A single interrupt output combines each flag with its enable.

A parameter selects between two variants. The scatter-gather variant counts only frame-end packets and has coalescing. The direct-register variant flags every completed transfer, ties the descriptor-related bits to zero and shows fixed coalescing fields.

Top module: `dma_chan_status`

## Requirements
- R1: After reset the status word reads 0x0001_0001, with bit 3 additionally set in the scatter-gather variant. Halted is bit 0, scatter-gather present is bit 3, the threshold status is bits 23:16 and the delay status is bits 31:24. The interrupt output and the run-clear output are 0.
- R2: Bits 2, 7, 11 and 15 always read 0, and a software write of all ones leaves the whole status word unchanged while no flag is set.
- R3: An enabled error event, on input bit i of the 6-bit error vector (0 DMA internal, 1 DMA slave, 2 DMA decode, 3 SG internal, 4 SG slave, 5 SG decode), sets status bit 4, 5, 6, 8, 9 or 10 respectively and the error interrupt flag (bit 14) in the next cycle. It also raises run-clear in that cycle and keeps it high while any error bit is set.
- R4: Halted (bit 0) clears one cycle after run is high with no error bit set. It is set only on a shutdown event while run is low, and stays 0 after an error until that event arrives.
- R5: Idle (bit 1) is set by an idle event and cleared by a busy event. It reads 0 while halted, and is 0 before the first idle event.
- R6: Bits 12 (completion), 13 (delay) and 14 (error interrupt) clear when software writes 1 to them. Writing 0 leaves them unchanged, and no other field changes on a write.
- R7: When a flag's set event and a software clear of that flag fall in the same cycle, the flag is 1 afterwards.
- R8: Until the first counted packet, the threshold status follows the programmed threshold, with 0 taken as 1. Each counted packet then decrements it. The packet that meets the threshold reloads the programmed value and sets the completion flag.
- R9: In the scatter-gather variant only packets with the frame-end qualifier are counted. In the direct variant every packet completion sets the completion flag.
- R10: A counted packet that does not meet the threshold, with a non-zero programmed delay, starts the delay status at 0. The delay status then rises by one every TICK_DIV cycles. When it would reach the programmed delay, the delay flag is set, the delay status returns to 0 and the threshold status reloads. Every counted packet restarts the delay at 0.
- R11: The interrupt output is 1 exactly when some flag among bits 12, 13 and 14 is set together with its enable input.
- R12: In the direct variant, bits 4, 8, 9, 10 and 13 stay 0 and those error inputs cause neither run-clear nor the error flag. The threshold status reads 0x01 and the delay status 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en_i | input | 1 | Run/stop control bit |
| ioc_en_i | input | 1 | Completion interrupt enable |
| dly_en_i | input | 1 | Delay interrupt enable |
| err_en_i | input | 1 | Error interrupt enable |
| thr_prog_i | input | 8 | Programmed packet threshold |
| dly_prog_i | input | 8 | Programmed delay in timer ticks |
| pkt_done_i | input | 1 | Packet completed pulse |
| pkt_eof_i | input | 1 | Frame-end qualifier for pkt_done_i |
| idle_ev_i | input | 1 | Channel reached idle pulse |
| busy_ev_i | input | 1 | Channel became busy pulse |
| shutdown_i | input | 1 | Engine fully stopped pulse |
| err_ev_i | input | 6 | Error event pulses, by class |
| sw_wr_i | input | 1 | Software write strobe to the status word |
| sw_wdata_i | input | 32 | Software write data |
| status_o | output | 32 | Live status word |
| run_clr_o | output | 1 | Request to force run/stop to 0 |
| irq_o | output | 1 | Channel interrupt |

## Verification
The bench builds two copies side by side from the same stimulus: one in the scatter-gather variant and one in the direct variant, both with TICK_DIV of 2. The short tick makes every delay setting from 1 to 4 run to timeout within a few cycles, so the delay status can be compared against an arithmetic count at every cycle. Thresholds from 0 to 5 are swept over more than two full reload periods. Each of the six error classes is applied in turn. All eight enable combinations are applied with every flag set.

// File: rtl/dma_stat_pkg.sv
// Package: shared constants for the channel status word.
// Assumes: the status word is 32 bits with 8-bit threshold and delay fields.
package dma_stat_pkg;
    localparam int WORD_W   = 32;
    localparam int FLD_W    = 8;
    localparam int NUM_ERR  = 6;
    localparam int NUM_FLAG = 3;
    localparam int BIT_HALT = 0;
    localparam int BIT_IDLE = 1;
    localparam int BIT_SGIN = 3;
    localparam int BIT_FLG0 = 12;
    localparam int THR_LSB  = 16;
    localparam int DLY_LSB  = 24;

    // Error class i sits at bit 4..6 for the data errors, 8..10 for descriptor errors.
    function automatic int err_pos(input int i);
        return (i < 3) ? (4 + i) : (5 + i);
    endfunction
endpackage

// File: rtl/dma_stat_runctl.sv
// Module: run/halt/idle tracking and sticky error capture.
// Assumes: event inputs are single-cycle pulses; ERR_MASK lists the error
// classes that exist in the selected variant, the others are ignored.
module dma_stat_runctl #(
    parameter int NUM_ERR = 6,
    parameter logic [NUM_ERR-1:0] ERR_MASK = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic               shut_i,
    input  logic               idle_ev_i,
    input  logic               busy_ev_i,
    input  logic [NUM_ERR-1:0] err_ev_i,
    output logic               halted_o,
    output logic               idle_o,
    output logic [NUM_ERR-1:0] err_flags_o,
    output logic               err_any_ev_o,
    output logic               run_clr_o
);
    logic               halted_q;
    logic               idle_q;
    logic [NUM_ERR-1:0] err_q;
    logic [NUM_ERR-1:0] err_live;

    assign err_live     = err_ev_i & ERR_MASK;
    assign err_any_ev_o = |err_live;
    assign run_clr_o    = err_any_ev_o | (|err_q);
    assign halted_o     = halted_q;
    assign idle_o       = idle_q & ~halted_q;
    assign err_flags_o  = err_q;

    // Purpose: halted follows the shutdown handshake and the run bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halted_q <= 1'b1;
        end else if (!run_i && shut_i) begin
            halted_q <= 1'b1;
        end else if (run_i && (err_q == '0)) begin
            halted_q <= 1'b0;
        end
    end

    // Purpose: idle is set by the engine's idle report and dropped on busy or halt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q <= 1'b0;
        end else if (halted_q || busy_ev_i) begin
            idle_q <= 1'b0;
        end else if (idle_ev_i) begin
            idle_q <= 1'b1;
        end
    end

    // Purpose: error classes are sticky until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= '0;
        end else begin
            err_q <= err_q | err_live;
        end
    end

    // R4: halted only rises after a shutdown report with run low
    a_r4_halt_on_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted_q) |-> $past(shut_i && !run_i));
    // R3: run-clear stays high after an error
    a_r3_runclr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        err_any_ev_o |=> run_clr_o);
    // R5: idle only rises from an idle report
    a_r5_idle_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_q) |-> $past(idle_ev_i));
endmodule

// File: rtl/dma_stat_coal.sv
// Module: packet-threshold countdown and delay timer for interrupt coalescing.
// Assumes: pkt_i pulses once per counted packet; TICK_DIV >= 1 cycles per tick.
module dma_stat_coal #(
    parameter int FLD_W    = 8,
    parameter int TICK_DIV = 16,
    localparam int PRE_W   = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_i,
    input  logic [FLD_W-1:0] thr_prog_i,
    input  logic [FLD_W-1:0] dly_prog_i,
    output logic             ioc_set_o,
    output logic             dly_set_o,
    output logic [FLD_W-1:0] thr_sts_o,
    output logic [FLD_W-1:0] dly_sts_o
);
    logic             started_q;
    logic             armed_q;
    logic [FLD_W-1:0] thr_q;
    logic [FLD_W-1:0] dly_q;
    logic [PRE_W-1:0] pre_q;
    logic [FLD_W-1:0] thr_eff;
    logic [FLD_W-1:0] thr_cur;
    logic             tick;
    logic             meet;
    logic             timeout;

    assign thr_eff   = (thr_prog_i == '0) ? FLD_W'(1) : thr_prog_i;
    assign thr_cur   = started_q ? thr_q : thr_eff;
    assign tick      = armed_q && (pre_q == PRE_W'(TICK_DIV - 1));
    assign meet      = (thr_cur <= FLD_W'(1));
    assign timeout   = !pkt_i && tick &&
                       ({1'b0, dly_q} + 1'b1 >= {1'b0, dly_prog_i});
    assign ioc_set_o = pkt_i && meet;
    assign dly_set_o = timeout;
    assign thr_sts_o = thr_q;
    assign dly_sts_o = dly_q;

    // Purpose: count packets down, arm and run the delay timer, reload on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started_q <= 1'b0;
            armed_q   <= 1'b0;
            thr_q     <= FLD_W'(1);
            dly_q     <= '0;
            pre_q     <= '0;
        end else if (pkt_i) begin
            started_q <= 1'b1;
            pre_q     <= '0;
            dly_q     <= '0;
            if (meet) begin
                thr_q   <= thr_eff;
                armed_q <= 1'b0;
            end else begin
                thr_q   <= thr_cur - 1'b1;
                armed_q <= (dly_prog_i != '0);
            end
        end else begin
            if (!started_q) begin
                thr_q <= thr_eff;
            end
            if (armed_q) begin
                pre_q <= tick ? '0 : pre_q + 1'b1;
            end
            if (tick) begin
                if (timeout) begin
                    armed_q <= 1'b0;
                    dly_q   <= '0;
                    thr_q   <= thr_eff;
                end else begin
                    dly_q <= dly_q + 1'b1;
                end
            end
        end
    end

    // R8: threshold status never reaches zero
    a_r8_thr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        thr_q != '0);
    // R10: every counted packet restarts the delay count
    a_r10_delay_restart: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_i |=> (dly_q == '0));
endmodule

// File: rtl/dma_stat_flags.sv
// Module: three sticky interrupt flags with write-one-to-clear and the irq OR.
// Assumes: flag order is [0] completion, [1] delay, [2] error.
module dma_stat_flags #(
    parameter int NUM_FLAG = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_FLAG-1:0] set_i,
    input  logic                wr_i,
    input  logic [NUM_FLAG-1:0] wr_clr_i,
    input  logic [NUM_FLAG-1:0] en_i,
    output logic [NUM_FLAG-1:0] flags_o,
    output logic                irq_o
);
    logic [NUM_FLAG-1:0] flag_q;
    logic [NUM_FLAG-1:0] clr;

    assign clr     = wr_i ? wr_clr_i : '0;
    assign flags_o = flag_q;
    assign irq_o   = |(flag_q & en_i);

    // Purpose: hardware set takes priority over a same-cycle software clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= (flag_q & ~clr) | set_i;
        end
    end

    // R7: a set event is never lost
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((flag_q & $past(set_i)) == $past(set_i)));
    // R6: a written one clears a flag with no concurrent set
    a_r6_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> ((flag_q & $past(wr_clr_i & ~set_i)) == '0));
endmodule

// File: rtl/dma_chan_status.sv
// Module: status word and interrupt logic of one memory-to-stream DMA channel.
// Assumes: engine events are single-cycle pulses; SG_MODE=1 selects the
// scatter-gather variant, 0 the direct-register variant.
module dma_chan_status
    import dma_stat_pkg::*;
#(
    parameter bit SG_MODE  = 1'b1,
    parameter int TICK_DIV = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run_en_i,
    input  logic        ioc_en_i,
    input  logic        dly_en_i,
    input  logic        err_en_i,
    input  logic [7:0]  thr_prog_i,
    input  logic [7:0]  dly_prog_i,
    input  logic        pkt_done_i,
    input  logic        pkt_eof_i,
    input  logic        idle_ev_i,
    input  logic        busy_ev_i,
    input  logic        shutdown_i,
    input  logic [5:0]  err_ev_i,
    input  logic        sw_wr_i,
    input  logic [31:0] sw_wdata_i,
    output logic [31:0] status_o,
    output logic        run_clr_o,
    output logic        irq_o
);
    localparam logic [NUM_ERR-1:0] ERR_MASK = SG_MODE ? 6'b111111 : 6'b000110;

    logic               halted;
    logic               idle;
    logic [NUM_ERR-1:0] err_flags;
    logic               err_any_ev;
    logic               ioc_set;
    logic               dly_set;
    logic [FLD_W-1:0]   thr_sts;
    logic [FLD_W-1:0]   dly_sts;
    logic [NUM_FLAG-1:0] flags;

    dma_stat_runctl #(
        .NUM_ERR  (NUM_ERR),
        .ERR_MASK (ERR_MASK)
    ) u_runctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (run_en_i),
        .shut_i       (shutdown_i),
        .idle_ev_i    (idle_ev_i),
        .busy_ev_i    (busy_ev_i),
        .err_ev_i     (err_ev_i),
        .halted_o     (halted),
        .idle_o       (idle),
        .err_flags_o  (err_flags),
        .err_any_ev_o (err_any_ev),
        .run_clr_o    (run_clr_o)
    );

    generate
        if (SG_MODE) begin : g_sg
            dma_stat_coal #(
                .FLD_W    (FLD_W),
                .TICK_DIV (TICK_DIV)
            ) u_coal (
                .clk        (clk),
                .rst_n      (rst_n),
                .pkt_i      (pkt_done_i & pkt_eof_i),
                .thr_prog_i (thr_prog_i),
                .dly_prog_i (dly_prog_i),
                .ioc_set_o  (ioc_set),
                .dly_set_o  (dly_set),
                .thr_sts_o  (thr_sts),
                .dly_sts_o  (dly_sts)
            );
        end else begin : g_direct
            assign ioc_set = pkt_done_i;
            assign dly_set = 1'b0;
            assign thr_sts = FLD_W'(1);
            assign dly_sts = '0;
        end
    endgenerate

    dma_stat_flags #(
        .NUM_FLAG (NUM_FLAG)
    ) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    ({err_any_ev, dly_set, ioc_set}),
        .wr_i     (sw_wr_i),
        .wr_clr_i (sw_wdata_i[BIT_FLG0 +: NUM_FLAG]),
        .en_i     ({err_en_i, dly_en_i, ioc_en_i}),
        .flags_o  (flags),
        .irq_o    (irq_o)
    );

    // Purpose: assemble the status word; unlisted bits stay zero.
    always_comb begin
        status_o = '0;
        status_o[BIT_HALT] = halted;
        status_o[BIT_IDLE] = idle;
        status_o[BIT_SGIN] = SG_MODE;
        for (int i = 0; i < NUM_ERR; i++) begin
            status_o[err_pos(i)] = err_flags[i];
        end
        status_o[BIT_FLG0 +: NUM_FLAG] = flags;
        status_o[THR_LSB +: FLD_W] = thr_sts;
        status_o[DLY_LSB +: FLD_W] = dly_sts;
    end

    // R2: reserved bits never read as one
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[2] | status_o[7] | status_o[11] | status_o[15]) == 1'b0);
endmodule

// File: tb/dma_chan_status_bench.sv
module dma_chan_status_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TDIV       = 2;

    logic clk = 1'b0;
    logic rst_n;
    logic run_en, ioc_en, dly_en, err_en;
    logic [7:0] thr_prog, dly_prog;
    logic pkt_done, pkt_eof, idle_ev, busy_ev, shutdown;
    logic [5:0] err_ev;
    logic sw_wr;
    logic [31:0] sw_wdata;
    logic [31:0] st_sg, st_dr;
    logic rc_sg, rc_dr, irq_sg, irq_dr;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chan_status #(.SG_MODE(1'b1), .TICK_DIV(TDIV)) u_dma_chan_status (
        .clk(clk), .rst_n(rst_n), .run_en_i(run_en), .ioc_en_i(ioc_en),
        .dly_en_i(dly_en), .err_en_i(err_en), .thr_prog_i(thr_prog),
        .dly_prog_i(dly_prog), .pkt_done_i(pkt_done), .pkt_eof_i(pkt_eof),
        .idle_ev_i(idle_ev), .busy_ev_i(busy_ev), .shutdown_i(shutdown),
        .err_ev_i(err_ev), .sw_wr_i(sw_wr), .sw_wdata_i(sw_wdata),
        .status_o(st_sg), .run_clr_o(rc_sg), .irq_o(irq_sg));

    dma_chan_status #(.SG_MODE(1'b0), .TICK_DIV(TDIV)) u_dma_chan_status_direct (
        .clk(clk), .rst_n(rst_n), .run_en_i(run_en), .ioc_en_i(ioc_en),
        .dly_en_i(dly_en), .err_en_i(err_en), .thr_prog_i(thr_prog),
        .dly_prog_i(dly_prog), .pkt_done_i(pkt_done), .pkt_eof_i(pkt_eof),
        .idle_ev_i(idle_ev), .busy_ev_i(busy_ev), .shutdown_i(shutdown),
        .err_ev_i(err_ev), .sw_wr_i(sw_wr), .sw_wdata_i(sw_wdata),
        .status_o(st_dr), .run_clr_o(rc_dr), .irq_o(irq_dr));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; run_en = 0; ioc_en = 0; dly_en = 0; err_en = 0;
        thr_prog = 8'd1; dly_prog = 8'd0; pkt_done = 0; pkt_eof = 0;
        idle_ev = 0; busy_ev = 0; shutdown = 0; err_ev = '0;
        sw_wr = 0; sw_wdata = '0;
        cyc(2);
        rst_n = 1'b1;
        cyc(1);
    endtask

    task automatic pkt(input logic eof);
        pkt_done = 1'b1; pkt_eof = eof;
        cyc(1);
        pkt_done = 1'b0; pkt_eof = 1'b0;
    endtask

    task automatic w1c(input logic [31:0] d);
        sw_wr = 1'b1; sw_wdata = d;
        cyc(1);
        sw_wr = 1'b0; sw_wdata = '0;
    endtask

    task automatic pulse_shut();
        shutdown = 1'b1; cyc(1); shutdown = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 sg word", st_sg, 32'h0001_0009);
        chk("R1 direct word", st_dr, 32'h0001_0001);
        chk("R1 irq/runclr", {irq_sg, irq_dr, rc_sg, rc_dr}, 0);
        // R2 reserved bits and non-flag fields ignore writes
        w1c(32'hFFFF_FFFF);
        chk("R2 sg write ignored", st_sg, 32'h0001_0009);
        chk("R2 direct write ignored", st_dr, 32'h0001_0001);

        // R4 halted clears on run; R5 idle behaviour
        run_en = 1'b1; cyc(1);
        chk("R4 halted cleared", {st_sg[0], st_dr[0]}, 0);
        chk("R5 idle before first done", {st_sg[1], st_dr[1]}, 0);
        idle_ev = 1'b1; cyc(1); idle_ev = 1'b0;
        chk("R5 idle set", {st_sg[1], st_dr[1]}, 2'b11);
        busy_ev = 1'b1; cyc(1); busy_ev = 1'b0;
        chk("R5 idle cleared by busy", {st_sg[1], st_dr[1]}, 0);
        idle_ev = 1'b1; cyc(1); idle_ev = 1'b0;
        run_en = 1'b0; cyc(2);
        chk("R4 no halt without shutdown", {st_sg[0], st_dr[0]}, 0);
        pulse_shut();
        chk("R4 halted after shutdown", {st_sg[0], st_dr[0]}, 2'b11);
        chk("R5 idle zero while halted", {st_sg[1], st_dr[1]}, 0);

        // R8 R9 threshold sweep
        for (int t = 0; t < 6; t++) begin
            int te;
            te = (t == 0) ? 1 : t;
            do_reset();
            run_en = 1'b1; ioc_en = 1'b1; thr_prog = 8'(t);
            cyc(2);
            chk("R8 thr before first packet", st_sg[23:16], 32'(te));
            for (int k = 1; k <= 2 * te + 1; k++) begin
                logic hit;
                hit = ((k % te) == 0);
                pkt(1'b1);
                chk("R8 thr count", st_sg[23:16], hit ? 32'(te) : 32'(te - (k % te)));
                chk("R8 completion flag", st_sg[12], 32'(hit));
                chk("R11 irq follows completion", irq_sg, 32'(hit));
                chk("R9 direct every transfer", st_dr[12], 1);
                w1c(32'h0000_1000);
                chk("R6 completion cleared", {st_sg[12], st_dr[12]}, 0);
            end
        end

        // R9 non-frame-end packet
        do_reset();
        run_en = 1'b1; thr_prog = 8'd2; cyc(2);
        pkt(1'b0);
        chk("R9 sg ignores non-eof", {st_sg[23:16], 7'd0, st_sg[12]}, {8'd2, 8'd0});
        chk("R9 direct counts any packet", st_dr[12], 1);
        w1c(32'h0);
        chk("R6 zero write keeps flag", st_dr[12], 1);

        // R10 delay sweep
        for (int p = 1; p <= 4; p++) begin
            do_reset();
            run_en = 1'b1; thr_prog = 8'd4; dly_prog = 8'(p); dly_en = 1'b1;
            cyc(2);
            pkt(1'b1);
            for (int j = 1; j < 2 * p; j++) begin
                cyc(1);
                chk("R10 delay count", {st_sg[31:24], 7'd0, st_sg[13]}, {8'(j / TDIV), 8'd0});
            end
            cyc(1);
            chk("R10 delay flag set", {st_sg[31:24], st_sg[23:16], 7'd0, st_sg[13]}, {8'd0, 8'd4, 8'd1});
            chk("R11 irq on delay", irq_sg, 1);
            chk("R12 direct fixed fields", {st_dr[31:16], 3'd0, st_dr[13]}, {16'h0001, 4'd0});
        end
        pkt(1'b1); cyc(3);
        chk("R10 delay running", st_sg[31:24], 1);
        pkt(1'b1);
        chk("R10 packet restarts delay", st_sg[31:24], 0);

        // R3 R4 R12 error classes
        for (int i = 0; i < 6; i++) begin
            int pos;
            logic dr_has;
            pos = (i < 3) ? 4 + i : 5 + i;
            dr_has = (i == 1) || (i == 2);
            do_reset();
            run_en = 1'b1; err_en = 1'b1; cyc(2);
            err_ev = 6'(1 << i); cyc(1); err_ev = '0;
            chk("R3 sg error bit", st_sg[pos], 1);
            chk("R3 sg err flag and runclr", {st_sg[14], rc_sg, irq_sg}, 3'b111);
            chk("R4 sg not halted yet", st_sg[0], 0);
            if (dr_has) chk("R3 direct error", {st_dr[pos], st_dr[14], rc_dr}, 3'b111);
            else chk("R12 direct ignores class", {st_dr, rc_dr}, {32'h0001_0000, 1'b0});
            cyc(3);
            chk("R3 runclr held", rc_sg, 1);
            w1c(32'h0000_4000);
            chk("R6 err flag cleared, class kept", {st_sg[14], st_sg[pos]}, 2'b01);
            run_en = 1'b0; cyc(2);
            chk("R4 waits for shutdown", st_sg[0], 0);
            pulse_shut();
            chk("R4 halted after error shutdown", st_sg[0], 1);
        end

        // R7 set wins over clear
        do_reset();
        run_en = 1'b1; thr_prog = 8'd1; cyc(2);
        pkt(1'b1);
        chk("R7 flag set", st_sg[12], 1);
        pkt_done = 1'b1; pkt_eof = 1'b1; sw_wr = 1'b1; sw_wdata = 32'h0000_1000;
        cyc(1);
        pkt_done = 1'b0; pkt_eof = 1'b0; sw_wr = 1'b0; sw_wdata = '0;
        chk("R7 set beats clear", {st_sg[12], st_dr[12]}, 2'b11);
        w1c(32'h0000_1000);
        chk("R6 clear alone", st_sg[12], 0);

        // R11 enable sweep with all three flags set
        do_reset();
        run_en = 1'b1; thr_prog = 8'd2; dly_prog = 8'd1; cyc(2);
        pkt(1'b1); cyc(2);
        pkt(1'b1); pkt(1'b1);
        err_ev = 6'b000010; cyc(1); err_ev = '0;
        chk("R11 all flags set", st_sg[14:12], 3'b111);
        for (int e = 0; e < 8; e++) begin
            ioc_en = e[0]; dly_en = e[1]; err_en = e[2];
            cyc(1);
            chk("R11 irq vs enables", irq_sg, 32'(e != 0));
        end
        w1c(32'h0000_1000);
        ioc_en = 1'b1; dly_en = 1'b0; err_en = 1'b0; cyc(1);
        chk("R11 enabled flag cleared", irq_sg, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule